// File: doc/BRIEF.md
# NAND Flash Page Read Sequencer

This block sits on the host side of an 8-bit NAND flash bus and turns simple read requests into bus transactions. Each request carries a row address, a starting column and a byte count. The sequencer drives the command latch, address latch, write strobe and read strobe, and it watches the ready/busy line. The bytes it reads come back on a valid/ready stream, and a one-cycle completion pulse follows the last accepted byte.

The sequencer remembers which row is currently loaded in the device's page buffer. If a request names a different row, or no page is loaded, it runs a full array load: a setup command, column and row address cycles, a confirm command, and a wait on ready/busy. If the request names the row that is already loaded, it sends only the short column-change command with two column bytes, and it reads at once with no array access and no busy wait. A host reads scattered fields of one page by sending a series of requests for the same row. A watchdog bounds the busy wait. When it expires, the sequencer reports an error and forgets the loaded page.

Top module: `nand_page_fetch`

## Requirements
- R1: While reset is held, and right after it, req_ready is 1, nf_we_n and nf_re_n are 1, nf_cle and nf_ale are 0, and out_valid, done and err are 0.
- R2: A full load latches, on successive rising edges of nf_we_n, the following seven bytes. First a command 0x00 with nf_cle=1 and nf_ale=0. Then the column low byte, the column high byte, and the three row bytes from least significant up, each with nf_ale=1 and nf_cle=0. Last a command 0x30. Command and address latches are never both high.
- R3: After the 0x30 confirm, no read strobe falls until ready/busy has gone low and then returned high.
- R4: A request returns exactly req_len bytes (req_len is at least 1). Byte i is the page byte at column req_col+i. out_last is 1 only on the final byte.
- R5: A request whose row equals the loaded row, after a load that completed, latches only four bytes: command 0x05, column low, column high, command 0xE0. No busy wait follows.
- R6: A request for a row other than the loaded one always starts a new full load, as in R2.
- R7: Each write strobe stays low for exactly T_WLO clock cycles and each read strobe for exactly T_RLO cycles. The strobes then stay high for at least T_WHI and T_RHI cycles.
- R8: If ready/busy does not go low and back high within TO_LIM cycles, err pulses for one cycle, no bytes are returned, done does not pulse, and the next request for any row runs a full load.
- R9: done pulses for exactly one cycle, in the cycle after the final byte is accepted.
- R10: While out_valid is 1 and out_ready is 0, out_data and out_last hold their values and out_valid stays 1.
- R11: req_ready is 1 only while the sequencer is idle. While it is idle, neither strobe is low and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle if valid |
| req_row | input | 8*ROW_CYC | Row (page) address |
| req_col | input | 8*COL_CYC | Starting column |
| req_len | input | LEN_W | Number of bytes to read, at least 1 |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 8 | Byte driven onto the flash data bus |
| nf_dq_oe | output | 1 | Drive enable for nf_dq_o |
| nf_dq_i | input | 8 | Byte read from the flash data bus |
| nf_rb | input | 1 | Ready/busy, high when ready |
| out_valid | output | 1 | Read byte available |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Read byte |
| out_last | output | 1 | Final byte of the request |
| done | output | 1 | One-cycle pulse after the final byte is accepted |
| err | output | 1 | One-cycle pulse on busy-wait timeout |

## Verification
A wrong step counter or a wrong mode flag shows up in the latched command and address sequence of the same request. That happens within a few strobe periods: a wrong byte, a missing command, or a full load where a column jump was due. A stale record of the loaded page shows up on the next request for that row, which either reloads or reads the wrong data. A fault in the byte counter or the capture register shows up on the stream as a wrong count, a misplaced last flag or a wrong value, and the bench compares these against the page content it computes. Faults in strobe timing or in the busy wait are caught one strobe or one busy period later, by the width measurements and by the check on read strobes that fall during busy.

// File: rtl/nfr_pkg.sv
package nfr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_BUSY,
    ST_READ,
    ST_PUSH
  } seq_st_e;

  localparam logic [7:0] OP_LOAD_SETUP = 8'h00;
  localparam logic [7:0] OP_LOAD_GO    = 8'h30;
  localparam logic [7:0] OP_JUMP_SETUP = 8'h05;
  localparam logic [7:0] OP_JUMP_GO    = 8'hE0;

endpackage

// File: rtl/nfr_strobe.sv
// One low-then-high strobe pulse per request, widths in clock cycles.
module nfr_strobe #(
  parameter int LO_CYC = 2,
  parameter int HI_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic strobe_n,
  output logic cap,
  output logic fin
);
  localparam int MAXC = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI} ph_e;

  ph_e           ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    case (ph_q)
      PH_IDLE: if (go) begin
        ph_d  = PH_LO;
        cnt_d = CW'(LO_CYC - 1);
      end
      PH_LO: if (cnt_q == '0) begin
        ph_d  = PH_HI;
        cnt_d = CW'(HI_CYC - 1);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      PH_HI: if (cnt_q == '0) begin
        ph_d = PH_IDLE;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign strobe_n = (ph_q != PH_LO);
  assign cap      = (ph_q == PH_LO) && (cnt_q == '0);
  assign fin      = (ph_q == PH_HI) && (cnt_q == '0);

endmodule

// File: rtl/nfr_rb_watch.sv
// Waits for ready/busy to fall and rise again, bounded by a watchdog.
module nfr_rb_watch #(
  parameter int TO_LIM = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rb,
  output logic ok,
  output logic tmo
);
  localparam int CW = $clog2(TO_LIM + 1);

  typedef enum logic [1:0] {W_IDLE, W_LOW, W_HIGH} w_e;

  w_e            ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    sync_q;
  logic          rb_s;
  logic          expired;

  assign rb_s    = sync_q[1];
  assign expired = (cnt_q == CW'(TO_LIM - 1));

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    ok    = 1'b0;
    tmo   = 1'b0;
    case (ph_q)
      W_IDLE: if (start) begin
        ph_d  = W_LOW;
        cnt_d = '0;
      end
      W_LOW: if (expired) begin
        tmo  = 1'b1;
        ph_d = W_IDLE;
      end else begin
        cnt_d = cnt_q + 1'b1;
        if (!rb_s) ph_d = W_HIGH;
      end
      W_HIGH: if (expired) begin
        tmo  = 1'b1;
        ph_d = W_IDLE;
      end else if (rb_s) begin
        ok   = 1'b1;
        ph_d = W_IDLE;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      default: ph_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= W_IDLE;
      cnt_q  <= '0;
      sync_q <= 2'b11;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sync_q <= {sync_q[0], rb};
    end
  end

endmodule

// File: rtl/nand_page_fetch.sv
module nand_page_fetch
  import nfr_pkg::*;
#(
  parameter int COL_CYC = 2,
  parameter int ROW_CYC = 3,
  parameter int LEN_W   = 12,
  parameter int T_WLO   = 2,
  parameter int T_WHI   = 2,
  parameter int T_RLO   = 2,
  parameter int T_RHI   = 1,
  parameter int TO_LIM  = 4096,
  localparam int COL_W  = 8 * COL_CYC,
  localparam int ROW_W  = 8 * ROW_CYC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic [LEN_W-1:0] req_len,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we_n,
  output logic             nf_re_n,
  output logic [7:0]       nf_dq_o,
  output logic             nf_dq_oe,
  input  logic [7:0]       nf_dq_i,
  input  logic             nf_rb,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic             done,
  output logic             err
);
  localparam int STP_W = $clog2(COL_CYC + ROW_CYC + 2);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rs_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  seq_st_e          st_q, st_d;
  logic [STP_W-1:0] stp_q, stp_d, last_stp;
  logic             jump_q, jump_d;
  logic [ROW_W-1:0] row_q, page_row_q;
  logic [COL_W-1:0] col_q;
  logic [LEN_W-1:0] left_q, left_d;
  logic             page_ok_q;
  logic [7:0]       byte_q;
  logic             done_q, done_d, err_q, err_d;
  logic             take, page_set, page_clr;
  logic             we_go, we_fin, we_cap;
  logic             re_go, re_fin, re_cap;
  logic             rb_start, rb_ok, rb_tmo;
  logic             is_cmd;
  logic [7:0]       step_byte;

  nfr_strobe #(.LO_CYC(T_WLO), .HI_CYC(T_WHI)) u_we (
    .clk(clk), .rst_n(rst_i_n), .go(we_go),
    .strobe_n(nf_we_n), .cap(we_cap), .fin(we_fin)
  );

  nfr_strobe #(.LO_CYC(T_RLO), .HI_CYC(T_RHI)) u_re (
    .clk(clk), .rst_n(rst_i_n), .go(re_go),
    .strobe_n(nf_re_n), .cap(re_cap), .fin(re_fin)
  );

  nfr_rb_watch #(.TO_LIM(TO_LIM)) u_rb (
    .clk(clk), .rst_n(rst_i_n), .start(rb_start), .rb(nf_rb),
    .ok(rb_ok), .tmo(rb_tmo)
  );

  // bus byte for the current step of the command/address sequence
  always_comb begin
    last_stp  = jump_q ? STP_W'(COL_CYC + 1) : STP_W'(COL_CYC + ROW_CYC + 1);
    is_cmd    = (stp_q == '0) || (stp_q == last_stp);
    step_byte = 8'h00;
    if (stp_q == '0)
      step_byte = jump_q ? OP_JUMP_SETUP : OP_LOAD_SETUP;
    else if (stp_q == last_stp)
      step_byte = jump_q ? OP_JUMP_GO : OP_LOAD_GO;
    else if (stp_q <= STP_W'(COL_CYC))
      step_byte = col_q[8*(int'(stp_q) - 1) +: 8];
    else
      step_byte = row_q[8*(int'(stp_q) - 1 - COL_CYC) +: 8];
  end

  assign take   = (st_q == ST_IDLE) && req_valid;
  assign jump_d = page_ok_q && (req_row == page_row_q);

  always_comb begin
    st_d     = st_q;
    stp_d    = stp_q;
    left_d   = left_q;
    we_go    = 1'b0;
    re_go    = 1'b0;
    rb_start = 1'b0;
    page_set = 1'b0;
    page_clr = 1'b0;
    done_d   = 1'b0;
    err_d    = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d   = ST_ISSUE;
        stp_d  = '0;
        left_d = req_len;
      end
      ST_ISSUE: begin
        we_go = 1'b1;
        if (we_fin) begin
          if (stp_q == last_stp) begin
            if (jump_q) begin
              st_d = ST_READ;
            end else begin
              st_d     = ST_BUSY;
              rb_start = 1'b1;
              page_clr = 1'b1;
            end
          end else begin
            stp_d = stp_q + 1'b1;
          end
        end
      end
      ST_BUSY: if (rb_ok) begin
        page_set = 1'b1;
        st_d     = ST_READ;
      end else if (rb_tmo) begin
        err_d = 1'b1;
        st_d  = ST_IDLE;
      end
      ST_READ: begin
        re_go = 1'b1;
        if (re_fin) st_d = ST_PUSH;
      end
      ST_PUSH: if (out_ready) begin
        if (left_q == LEN_W'(1)) begin
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          left_d = left_q - 1'b1;
          st_d   = ST_READ;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q       <= ST_IDLE;
      stp_q      <= '0;
      jump_q     <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      left_q     <= '0;
      page_ok_q  <= 1'b0;
      page_row_q <= '0;
      byte_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      st_q   <= st_d;
      stp_q  <= stp_d;
      left_q <= left_d;
      done_q <= done_d;
      err_q  <= err_d;
      if (take) begin
        jump_q <= jump_d;
        row_q  <= req_row;
        col_q  <= req_col;
      end
      if (page_set) begin
        page_ok_q  <= 1'b1;
        page_row_q <= row_q;
      end else if (page_clr) begin
        page_ok_q <= 1'b0;
      end
      if (re_cap) byte_q <= nf_dq_i;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign nf_cle    = (st_q == ST_ISSUE) && is_cmd;
  assign nf_ale    = (st_q == ST_ISSUE) && !is_cmd;
  assign nf_dq_o   = step_byte;
  assign nf_dq_oe  = (st_q == ST_ISSUE);
  assign out_valid = (st_q == ST_PUSH);
  assign out_data  = byte_q;
  assign out_last  = (st_q == ST_PUSH) && (left_q == LEN_W'(1));
  assign done      = done_q;
  assign err       = err_q;

endmodule

// File: rtl/nand_page_fetch_chk.sv
module nand_page_fetch_chk #(
  parameter int T_WLO = 2,
  parameter int T_RLO = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic       nf_we_n,
  input logic       nf_re_n,
  input logic       nf_rb,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       done,
  input logic       err
);
  logic [15:0] we_lo_cnt, re_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      re_lo_cnt <= '0;
    end else begin
      we_lo_cnt <= nf_we_n ? 16'd0 : we_lo_cnt + 16'd1;
      re_lo_cnt <= nf_re_n ? 16'd0 : re_lo_cnt + 16'd1;
    end
  end

  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(nf_cle && nf_ale));

  p_no_read_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !nf_rb |-> nf_re_n);

  p_we_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_we_n) |-> (we_lo_cnt == 16'(T_WLO)));

  p_re_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_re_n) |-> (re_lo_cnt == 16'(T_RLO)));

  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nf_we_n || nf_re_n);

  p_err_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_last));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nf_we_n && nf_re_n && !out_valid));

endmodule

bind nand_page_fetch nand_page_fetch_chk #(.T_WLO(T_WLO), .T_RLO(T_RLO)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .nf_cle(nf_cle), .nf_ale(nf_ale),
  .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_rb(nf_rb), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last), .done(done), .err(err)
);

// File: tb/nand_page_fetch_tb_top.sv
module nand_page_fetch_tb_top;
  localparam int COL_CYC  = 2;
  localparam int ROW_CYC  = 3;
  localparam int LEN_W    = 8;
  localparam int T_WLO    = 2;
  localparam int T_WHI    = 2;
  localparam int T_RLO    = 3;
  localparam int T_RHI    = 1;
  localparam int TO_LIM   = 64;
  localparam int BUSY_LEN = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [23:0] req_row;
  logic [15:0] req_col;
  logic [7:0]  req_len;
  logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [7:0]  nf_dq_o;
  logic [7:0]  nf_dq_i = 8'h00;
  logic        nf_rb = 1'b1;
  logic        out_valid, out_last, done, err;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;

  always #4 clk = ~clk;

  nand_page_fetch #(
    .COL_CYC(COL_CYC), .ROW_CYC(ROW_CYC), .LEN_W(LEN_W),
    .T_WLO(T_WLO), .T_WHI(T_WHI), .T_RLO(T_RLO), .T_RHI(T_RHI), .TO_LIM(TO_LIM)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_len(req_len),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rb(nf_rb),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .done(done), .err(err)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pb(input logic [23:0] r, input logic [15:0] c);
    return 8'(r[7:0] * 8'd13 + r[15:8] * 8'd5 + r[23:16] * 8'd3 + c[7:0] + c[15:8] * 8'd7);
  endfunction

  // flash device model
  logic [7:0]  m_addr [0:4];
  int          m_an = 0;
  logic [23:0] m_row = '0;
  logic [15:0] m_col = '0;
  logic [9:0]  lg [0:511];
  int          lg_n = 0;
  int          busy_req = 0;
  int          seen_req = 0;
  int          lowcnt = 0;
  bit          await_rb = 1'b0;
  bit          stuck = 1'b0;
  int          re_busy_viol = 0;

  always @(posedge nf_we_n) if (rst_n) begin
    if (lg_n < 512) begin
      lg[lg_n] = {nf_cle, nf_ale, nf_dq_o};
      lg_n++;
    end
    if (nf_cle) begin
      if (nf_dq_o == 8'h00 || nf_dq_o == 8'h05) m_an = 0;
      else if (nf_dq_o == 8'h30) begin
        m_row = {m_addr[4], m_addr[3], m_addr[2]};
        m_col = {m_addr[1], m_addr[0]};
        busy_req++;
      end else if (nf_dq_o == 8'hE0) m_col = {m_addr[1], m_addr[0]};
    end else if (nf_ale) begin
      if (m_an < 5) m_addr[m_an] = nf_dq_o;
      m_an++;
    end
  end

  always @(negedge nf_re_n) if (rst_n) begin
    if (await_rb || !nf_rb) re_busy_viol++;
    nf_dq_i = pb(m_row, m_col);
  end

  always @(posedge nf_re_n) if (rst_n) m_col = m_col + 16'd1;

  always @(negedge clk) begin
    if (!rst_n) begin
      nf_rb    = 1'b1;
      seen_req = busy_req;
      await_rb = 1'b0;
    end else if (seen_req != busy_req) begin
      seen_req = busy_req;
      nf_rb    = 1'b0;
      lowcnt   = 0;
      await_rb = 1'b1;
    end else if (!nf_rb && !stuck) begin
      if (lowcnt >= BUSY_LEN) begin
        nf_rb    = 1'b1;
        await_rb = 1'b0;
      end else lowcnt++;
    end
  end

  // stream consumer with back-pressure patterns
  int          bp = 0;
  int          cyc = 0;
  logic [7:0]  rx_d [0:1023];
  logic        rx_l [0:1023];
  int          rx_n = 0;
  int          done_cnt = 0;
  int          err_cnt = 0;
  int          hold_viol = 0;
  bit          pend = 1'b0;
  logic [8:0]  pend_v = '0;

  always @(negedge clk) if (rst_n) begin
    bit rdy;
    cyc++;
    rdy = (bp == 0) || ((cyc % (bp + 1)) == 0);
    if (pend && (!out_valid || {out_last, out_data} !== pend_v)) hold_viol++;
    pend = out_valid && !rdy;
    pend_v = {out_last, out_data};
    out_ready = rdy;
    if (out_valid && rdy && rx_n < 1024) begin
      rx_d[rx_n] = out_data;
      rx_l[rx_n] = out_last;
      rx_n++;
    end
    if (done) done_cnt++;
    if (err) err_cnt++;
  end

  // strobe width and idle monitor
  int wl = 0, rl = 0, wviol = 0, rviol = 0, idle_viol = 0;
  always @(negedge clk) if (rst_n) begin
    if (!nf_we_n) wl++;
    else begin
      if (wl != 0 && wl != T_WLO) wviol++;
      wl = 0;
    end
    if (!nf_re_n) rl++;
    else begin
      if (rl != 0 && rl != T_RLO) rviol++;
      rl = 0;
    end
    if (req_ready && (!nf_we_n || !nf_re_n || out_valid)) idle_viol++;
  end

  bit          pg_ok = 1'b0;
  logic [23:0] pg_row = '0;

  task automatic do_req(input logic [23:0] row, input logic [15:0] col, input int len, input bit tmo);
    bit         jmp;
    string      tg;
    logic [9:0] ex [0:6];
    int         ne, s_lg, s_rx, s_dn, s_er, w;
    jmp = pg_ok && (row == pg_row);
    if (jmp) begin
      tg = "R5";
      ex[0] = {2'b10, 8'h05};
      ex[1] = {2'b01, col[7:0]};
      ex[2] = {2'b01, col[15:8]};
      ex[3] = {2'b10, 8'hE0};
      ne = 4;
    end else begin
      tg = pg_ok ? "R6" : "R2";
      ex[0] = {2'b10, 8'h00};
      ex[1] = {2'b01, col[7:0]};
      ex[2] = {2'b01, col[15:8]};
      ex[3] = {2'b01, row[7:0]};
      ex[4] = {2'b01, row[15:8]};
      ex[5] = {2'b01, row[23:16]};
      ex[6] = {2'b10, 8'h30};
      ne = 7;
    end
    w = 0;
    while (!req_ready && w < 1000) begin @(negedge clk); w++; end
    s_lg = lg_n; s_rx = rx_n; s_dn = done_cnt; s_er = err_cnt;
    req_valid = 1'b1; req_row = row; req_col = col; req_len = 8'(len);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 busy ready", 32'(req_ready), 32'd0);
    w = 0;
    while (done_cnt == s_dn && err_cnt == s_er && w < 20000) begin @(negedge clk); w++; end
    repeat (3) @(negedge clk);
    chk({tg, " seq len"}, 32'(lg_n - s_lg), 32'(ne));
    for (int i = 0; i < ne; i++) chk({tg, " seq byte"}, 32'(lg[s_lg + i]), 32'(ex[i]));
    if (tmo) begin
      chk("R8 err pulse", 32'(err_cnt - s_er), 32'd1);
      chk("R8 no bytes", 32'(rx_n - s_rx), 32'd0);
      chk("R8 no done", 32'(done_cnt - s_dn), 32'd0);
      pg_ok = 1'b0;
    end else begin
      chk("R9 single done", 32'(done_cnt - s_dn), 32'd1);
      chk("R8 no err", 32'(err_cnt - s_er), 32'd0);
      chk("R4 count", 32'(rx_n - s_rx), 32'(len));
      for (int i = 0; i < len; i++) begin
        chk(jmp ? "R5 data" : "R4 data", 32'(rx_d[s_rx + i]), 32'(pb(row, col + 16'(i))));
        chk("R4 last", 32'(rx_l[s_rx + i]), 32'(i == len - 1));
      end
      pg_ok = 1'b1;
      pg_row = row;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R4 watchdog act=%0d exp=%0d", 200000, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [23:0] rows [0:2];
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_row = '0;
    req_col = '0;
    req_len = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 we_n", 32'(nf_we_n), 32'd1);
    chk("R1 re_n", 32'(nf_re_n), 32'd1);
    chk("R1 cle/ale", 32'({nf_cle, nf_ale}), 32'd0);
    chk("R1 out/done/err", 32'({out_valid, done, err}), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", 32'({req_ready, nf_we_n, nf_re_n, out_valid}), 32'hE);

    for (int b = 0; b < 3; b++) begin
      bp = b;
      rows[0] = 24'h000001 + 24'(b);
      rows[1] = 24'h12A5C3;
      rows[2] = 24'h7F00FE;
      for (int r = 0; r < 3; r++) begin
        do_req(rows[r], 16'(r * 16), 4, 1'b0);
        do_req(rows[r], 16'h0102, 1, 1'b0);
        do_req(rows[r], 16'h07FE, 5, 1'b0);
        do_req(rows[r], 16'h0000, 3, 1'b0);
      end
    end

    bp = 1;
    stuck = 1'b1;
    do_req(24'h00ABCD, 16'h0010, 2, 1'b1);
    stuck = 1'b0;
    while (!nf_rb) @(negedge clk);
    do_req(24'h00ABCD, 16'h0010, 2, 1'b0);
    do_req(24'h00ABCD, 16'h0020, 2, 1'b0);

    chk("R3 read during busy", 32'(re_busy_viol), 32'd0);
    chk("R7 write strobe width", 32'(wviol), 32'd0);
    chk("R7 read strobe width", 32'(rviol), 32'd0);
    chk("R10 hold under backpressure", 32'(hold_viol), 32'd0);
    chk("R11 idle quiet", 32'(idle_viol), 32'd0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule